// File: doc/BRIEF.md
# Register Sequence Command Executor

This block drains a circular buffer of fixed-size commands held in local memory. Each command performs a series of register accesses on a simple strobe-and-ready register bus. A producer writes commands into slots and moves a write pointer forward. The executor notices that its read pointer lags and fetches the slot word by word through a one-cycle-latency memory read port. It decodes the slot's header and issues the accesses that the command describes. Only after the last access of the command has been accepted does it release the slot, by stepping its read pointer.

There are two working command kinds. A read-modify-write command carries up to five triples, each giving a register address, a bit mask and a new value. For each triple the executor reads the register, replaces the masked bits, and writes the result back. A triple whose mask is all ones needs no read: the executor writes the value directly. A burst command carries one register address and up to fourteen data words, which are written one after another to that single address, for example to fill a lookup table through a data port. A null command, or a header with any other type code, is consumed without touching the bus.

Top module: `regseq_exec`

## Requirements
- R1: While reset is asserted, `ring_rd_ptr` is 0 and `mem_rd_en`, `bus_rd` and `bus_wr` are all low.
- R2: While `ring_rd_ptr` equals `ring_wr_ptr`, the block issues no memory reads and no bus accesses.
- R3: The header is slot word 0. Bits [10:0] hold the type and bits [15:11] hold the payload length in 32-bit words. Bits [31:16] are ignored. A type other than 1 or 2 (including 0) is consumed after the single header fetch, with no bus access.
- R4: For type 1, the entry count is min(length/3, 5), using integer division. Entry e occupies slot words 1+3e, 2+3e and 3+3e, holding address, mask and value. The entries are executed in order. Each entry reads the address and then writes (read_data & ~mask) | (value & mask) to the same address.
- R5: A type-1 entry whose mask is 32'hFFFFFFFF issues no read and writes its value directly.
- R6: For type 2, the data count is 0 when length is 0, and min(length-1, 14) otherwise. Slot word 1 is the address, and data words 2.. are written in order to that address.
- R7: A bus strobe stays high, with a stable address (and stable write data for a write), until `bus_ready` is sampled high. `bus_rd` and `bus_wr` are never high together. The write of an entry follows its read only after the read data has been taken.
- R8: `ring_rd_ptr` advances by exactly one slot, modulo 16, per command, and only after that command's last bus access has completed.
- R9: The memory word address is {slot, word} with 16 words per slot. The block fetches exactly the header plus the words that the decoded count uses, and no word beyond them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_wr_ptr | input | 4 | Producer slot index (next slot to be filled) |
| ring_rd_ptr | output | 4 | Slot index currently owned by the executor |
| mem_rd_en | output | 1 | Memory read request; data returns on the next cycle |
| mem_addr | output | 8 | Memory word address {slot, word} |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd_en` |
| bus_rd | output | 1 | Register read strobe, held until ready |
| bus_wr | output | 1 | Register write strobe, held until ready |
| bus_addr | output | 32 | Register address |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, taken in the cycle where `bus_rd` and `bus_ready` are both high |
| bus_ready | input | 1 | Target accepts the current access |

## Verification
The hardest situation to reach is a read-modify-write read that stalls for several cycles while the merge still has to use the data from the accepting cycle. The bench holds off `bus_ready` with a pseudo-random pattern, so reads and writes stall for varying lengths. It checks every written value against a shadow register file that it updates arithmetically. Length-field sweeps from 0 to 15, plus 31, cover both count clamps and the zero-count cases. A batch of queued commands that wraps the slot index exercises back-to-back slot hand-off.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CAPT,
        S_RD,
        S_WR,
        S_ADV
    } exec_state_e;

    typedef enum logic [2:0] {
        T_HDR,
        T_ADDR,
        T_MASK,
        T_VAL,
        T_DATA
    } load_tgt_e;

    typedef enum logic [1:0] {
        K_SKIP,
        K_RMW,
        K_BURST
    } cmd_kind_e;

    localparam int unsigned CMD_RMW   = 1;
    localparam int unsigned CMD_BURST = 2;

endpackage

// File: rtl/regseq_decode.sv
module regseq_decode
    import regseq_pkg::*;
#(
    parameter int TYPE_W    = 11,
    parameter int LEN_W     = 5,
    parameter int RMW_MAX   = 5,
    parameter int BURST_MAX = 14,
    parameter int RMW_WORDS = 3,
    parameter int CNT_W     = 4,
    localparam int HDR_W    = TYPE_W + LEN_W
) (
    input  logic [HDR_W-1:0] hdr,
    output cmd_kind_e        kind,
    output logic [CNT_W-1:0] count
);

    logic [TYPE_W-1:0] ctype;
    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  rmw_n;
    logic [LEN_W-1:0]  burst_n;

    always_comb begin
        ctype   = hdr[TYPE_W-1:0];
        len     = hdr[TYPE_W +: LEN_W];
        rmw_n   = len / LEN_W'(RMW_WORDS);
        burst_n = (len == '0) ? '0 : len - 1'b1;
        kind    = K_SKIP;
        count   = '0;
        if (ctype == TYPE_W'(CMD_RMW)) begin
            kind  = K_RMW;
            count = (rmw_n > LEN_W'(RMW_MAX)) ? CNT_W'(RMW_MAX) : CNT_W'(rmw_n);
        end else if (ctype == TYPE_W'(CMD_BURST)) begin
            kind  = K_BURST;
            count = (burst_n > LEN_W'(BURST_MAX)) ? CNT_W'(BURST_MAX) : CNT_W'(burst_n);
        end
        if (count == '0) begin
            kind = K_SKIP;
        end
    end

endmodule

// File: rtl/regseq_merge.sv
module regseq_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] value,
    output logic [DW-1:0] merged,
    output logic          mask_full
);

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign merged[i] = mask[i] ? value[i] : rd_data[i];
    end

    assign mask_full = &mask;

endmodule

// File: rtl/regseq_exec.sv
module regseq_exec
    import regseq_pkg::*;
#(
    parameter int SLOTS      = 16,
    parameter int SLOT_WORDS = 16,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int TYPE_W     = 11,
    parameter int LEN_W      = 5,
    parameter int RMW_MAX    = 5,
    parameter int BURST_MAX  = 14,
    localparam int PTR_W     = $clog2(SLOTS),
    localparam int WIDX_W    = $clog2(SLOT_WORDS),
    localparam int MEM_AW    = PTR_W + WIDX_W,
    localparam int CNT_W     = $clog2(BURST_MAX + 1),
    localparam int HDR_W     = TYPE_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ring_wr_ptr,
    output logic [PTR_W-1:0]  ring_rd_ptr,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ready
);

    typedef struct packed {
        exec_state_e        st;
        load_tgt_e          tgt;
        logic [PTR_W-1:0]   rdptr;
        logic [WIDX_W-1:0]  widx;
        logic [CNT_W-1:0]   remain;
        logic               burst;
        logic [AW-1:0]      addr;
        logic [DW-1:0]      mask;
        logic [DW-1:0]      val;
        logic [DW-1:0]      wdata;
    } core_t;

    localparam core_t CORE_RST = '{
        st:     S_IDLE,
        tgt:    T_HDR,
        rdptr:  '0,
        widx:   '0,
        remain: '0,
        burst:  1'b0,
        addr:   '0,
        mask:   '0,
        val:    '0,
        wdata:  '0
    };

    core_t core_d;
    core_t core_q;

    cmd_kind_e        dec_kind;
    logic [CNT_W-1:0] dec_count;
    logic [DW-1:0]    merged;
    logic             mask_full;

    regseq_decode #(
        .TYPE_W    (TYPE_W),
        .LEN_W     (LEN_W),
        .RMW_MAX   (RMW_MAX),
        .BURST_MAX (BURST_MAX),
        .RMW_WORDS (3),
        .CNT_W     (CNT_W)
    ) u_decode (
        .hdr   (mem_rdata[HDR_W-1:0]),
        .kind  (dec_kind),
        .count (dec_count)
    );

    regseq_merge #(
        .DW (DW)
    ) u_merge (
        .rd_data   (bus_rdata),
        .mask      (core_q.mask),
        .value     (core_q.val),
        .merged    (merged),
        .mask_full (mask_full)
    );

    always_comb begin
        core_d    = core_q;
        mem_rd_en = 1'b0;
        mem_addr  = {core_q.rdptr, core_q.widx};
        bus_rd    = (core_q.st == S_RD);
        bus_wr    = (core_q.st == S_WR);
        bus_addr  = core_q.addr;
        bus_wdata = core_q.wdata;

        case (core_q.st)
            S_IDLE: begin
                if (core_q.rdptr != ring_wr_ptr) begin
                    core_d.widx = '0;
                    core_d.tgt  = T_HDR;
                    core_d.st   = S_FETCH;
                end
            end
            S_FETCH: begin
                mem_rd_en = 1'b1;
                core_d.st = S_CAPT;
            end
            S_CAPT: begin
                core_d.widx = core_q.widx + 1'b1;
                core_d.st   = S_FETCH;
                case (core_q.tgt)
                    T_HDR: begin
                        core_d.remain = dec_count;
                        core_d.burst  = (dec_kind == K_BURST);
                        core_d.tgt    = T_ADDR;
                        if (dec_kind == K_SKIP) begin
                            core_d.st = S_ADV;
                        end
                    end
                    T_ADDR: begin
                        core_d.addr = mem_rdata;
                        core_d.tgt  = core_q.burst ? T_DATA : T_MASK;
                    end
                    T_MASK: begin
                        core_d.mask = mem_rdata;
                        core_d.tgt  = T_VAL;
                    end
                    T_VAL: begin
                        core_d.val   = mem_rdata;
                        core_d.wdata = mem_rdata;
                        core_d.st    = mask_full ? S_WR : S_RD;
                    end
                    T_DATA: begin
                        core_d.wdata = mem_rdata;
                        core_d.st    = S_WR;
                    end
                    default: begin
                        core_d.st = S_ADV;
                    end
                endcase
            end
            S_RD: begin
                if (bus_ready) begin
                    core_d.wdata = merged;
                    core_d.st    = S_WR;
                end
            end
            S_WR: begin
                if (bus_ready) begin
                    core_d.remain = core_q.remain - 1'b1;
                    if (core_q.remain == CNT_W'(1)) begin
                        core_d.st = S_ADV;
                    end else begin
                        core_d.st  = S_FETCH;
                        core_d.tgt = core_q.burst ? T_DATA : T_ADDR;
                    end
                end
            end
            S_ADV: begin
                core_d.rdptr = core_q.rdptr + 1'b1;
                core_d.st    = S_IDLE;
            end
            default: begin
                core_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= CORE_RST;
        end else begin
            core_q <= core_d;
        end
    end

    assign ring_rd_ptr = core_q.rdptr;

endmodule

// File: rtl/regseq_exec_chk.sv
module regseq_exec_chk #(
    parameter int PTR_W = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] ring_wr_ptr,
    input logic [PTR_W-1:0] ring_rd_ptr,
    input logic             mem_rd_en,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic             bus_ready
);

    // R7: read and write strobes are exclusive
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R7: a stalled write keeps strobe, address and data
    p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R7: a stalled read keeps strobe and address
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

    // R4: the write of an entry directly follows its completed read
    p_rmw_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd) |-> bus_wr);

    // R8: the pointer only ever steps by one
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_rd_ptr != $past(ring_rd_ptr)) |-> (ring_rd_ptr == PTR_W'($past(ring_rd_ptr) + 1'b1)));

    // R8: no release while an access is pending
    p_ptr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> $stable(ring_rd_ptr));

    // R2: nothing is fetched from an empty ring
    p_idle_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_rd_ptr == ring_wr_ptr) |-> !mem_rd_en);

endmodule

bind regseq_exec regseq_exec_chk #(
    .PTR_W (PTR_W),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_wr_ptr (ring_wr_ptr),
    .ring_rd_ptr (ring_rd_ptr),
    .mem_rd_en   (mem_rd_en),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ready   (bus_ready)
);

// File: tb/sim_regseq_exec.sv
`timescale 1ns/1ps
module sim_regseq_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [3:0]  wr_ptr = 4'd0;
    logic [3:0]  rd_ptr;
    logic        mem_rd_en;
    logic [7:0]  mem_addr;
    logic [31:0] mem_rdata = 32'd0;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ready = 1'b0;

    regseq_exec u0 (
        .clk(clk), .rst_n(rst_n),
        .ring_wr_ptr(wr_ptr), .ring_rd_ptr(rd_ptr),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    logic [31:0] mem [256];
    logic [31:0] regs [64];
    logic [31:0] exp_regs [64];
    logic [31:0] wl_a [2048];
    logic [31:0] wl_d [2048];
    logic [31:0] ex_a [2048];
    logic [31:0] ex_d [2048];
    int wn = 0, rn = 0, mrd = 0, viol = 0;
    int exn = 0, exrn = 0, exmr = 0, vpos = 0, wp = 0;
    int checks = 0, fails = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        fast = 1'b0;
    logic        pw = 1'b0, pr = 1'b0;
    logic [31:0] pa = 32'd0, pd = 32'd0;

    function automatic logic [31:0] reg_init(int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203);
    endfunction

    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_ready <= fast | (lfsr[0] & lfsr[3]) | lfsr[7];
    end

    assign bus_rdata = regs[bus_addr[5:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) regs[i] <= reg_init(i);
        end else begin
            if (mem_rd_en) begin
                mem_rdata <= mem[mem_addr];
                mrd <= mrd + 1;
            end
            if (bus_wr && bus_ready) begin
                regs[bus_addr[5:0]] <= bus_wdata;
                wl_a[wn % 2048] <= bus_addr;
                wl_d[wn % 2048] <= bus_wdata;
                wn <= wn + 1;
            end
            if (bus_rd && bus_ready) rn <= rn + 1;
            if ((bus_rd && bus_wr) ||
                (pw && !(bus_wr && bus_addr == pa && bus_wdata == pd)) ||
                (pr && !(bus_rd && bus_addr == pa)))
                viol <= viol + 1;
            pw <= bus_wr && !bus_ready;
            pr <= bus_rd && !bus_ready;
            pa <= bus_addr;
            pd <= bus_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic fill_junk(input int s);
        for (int w = 1; w < 16; w++) mem[s + w] = 32'hDEAD_0000 | 32'(w);
    endtask

    task automatic build_rmw(input int len, input int seed);
        int s, n;
        logic [31:0] a, m, v, d;
        s = wp * 16;
        n = len / 3;
        if (n > 5) n = 5;
        fill_junk(s);
        mem[s] = {16'hBEEF, 5'(len), 11'd1};
        exmr += 1 + 3 * n;
        for (int e = 0; e < n; e++) begin
            a = (32'(seed) << 8) | 32'((seed * 7 + e * 13) & 63);
            if (e % 3 == 1)      m = 32'hFFFF_FFFF;
            else if (e % 3 == 0) m = 32'h00FF_00F0 ^ 32'(seed);
            else                 m = 32'h0;
            v = (32'(seed) * 32'h9E37_79B9) ^ 32'(e);
            mem[s + 1 + 3 * e] = a;
            mem[s + 2 + 3 * e] = m;
            mem[s + 3 + 3 * e] = v;
            if (m != 32'hFFFF_FFFF) exrn++;
            d = (exp_regs[a[5:0]] & ~m) | (v & m);
            exp_regs[a[5:0]] = d;
            ex_a[exn % 2048] = a;
            ex_d[exn % 2048] = d;
            exn++;
        end
        wp = (wp + 1) % 16;
    endtask

    task automatic build_burst(input int len, input int seed);
        int s, n;
        logic [31:0] a, d;
        s = wp * 16;
        n = (len == 0) ? 0 : len - 1;
        if (n > 14) n = 14;
        fill_junk(s);
        mem[s] = {16'h7E57, 5'(len), 11'd2};
        a = 32'hC000_0000 | 32'((seed * 5) & 63);
        mem[s + 1] = a;
        exmr += (n > 0) ? 2 + n : 1;
        for (int k = 0; k < n; k++) begin
            d = 32'(seed) * 32'h0100_0000 + 32'(k) * 32'h0001_0001;
            mem[s + 2 + k] = d;
            exp_regs[a[5:0]] = d;
            ex_a[exn % 2048] = a;
            ex_d[exn % 2048] = d;
            exn++;
        end
        wp = (wp + 1) % 16;
    endtask

    task automatic build_other(input int ctype);
        int s;
        s = wp * 16;
        fill_junk(s);
        mem[s] = {16'h1234, 5'd15, 11'(ctype)};
        exmr += 1;
        wp = (wp + 1) % 16;
    endtask

    task automatic run(input string req);
        int guard;
        @(negedge clk);
        wr_ptr = 4'(wp);
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (rd_ptr != 4'(wp) && guard < 5000);
        repeat (2) @(negedge clk);
        chk(rd_ptr == 4'(wp), "R8", "read pointer after command", 32'(rd_ptr), 32'(wp));
        chk(wn == exn, req, "write count", 32'(wn), 32'(exn));
        chk(rn == exrn, "R5", "read count", 32'(rn), 32'(exrn));
        chk(mrd == exmr, "R9", "memory fetch count", 32'(mrd), 32'(exmr));
        for (int i = vpos; i < exn && i < wn; i++) begin
            chk(wl_a[i % 2048] == ex_a[i % 2048], req, "write address",
                wl_a[i % 2048], ex_a[i % 2048]);
            chk(wl_d[i % 2048] == ex_d[i % 2048], req, "write data",
                wl_d[i % 2048], ex_d[i % 2048]);
        end
        vpos = exn;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int m0;
        for (int i = 0; i < 64; i++) exp_regs[i] = reg_init(i);
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(rd_ptr == 4'd0, "R1", "reset pointer", 32'(rd_ptr), 32'd0);
        chk({mem_rd_en, bus_rd, bus_wr} == 3'b000, "R1", "reset strobes",
            32'({mem_rd_en, bus_rd, bus_wr}), 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R2: empty ring stays idle
        chk(mrd == 0 && rd_ptr == 4'd0, "R2", "fetches on empty ring", 32'(mrd), 32'd0);

        // R3: null and unknown types consumed silently
        fast = 1'b1;
        build_other(0);      run("R3");
        build_other(11'h7FF); run("R3");
        build_other(3);      run("R3");

        // R4 / R5: read-modify-write length sweep, stalled bus
        fast = 1'b0;
        for (int len = 0; len < 16; len++) begin
            build_rmw(len, len + 1);
            run("R4");
        end
        build_rmw(31, 40); run("R4");

        // R6: burst length sweep
        for (int len = 0; len < 16; len++) begin
            build_burst(len, len + 3);
            run("R6");
        end
        build_burst(31, 50); run("R6");

        // R8: several queued commands drained back to back
        build_rmw(15, 77);
        build_burst(31, 78);
        build_other(0);
        build_rmw(9, 79);
        run("R8");

        // R2: idle again once drained
        m0 = mrd;
        repeat (20) @(negedge clk);
        chk(mrd == m0, "R2", "fetches after drain", 32'(mrd), 32'(m0));

        // R7: handshake monitor
        chk(viol == 0, "R7", "handshake violations", 32'(viol), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule